// File: doc/BRIEF.md
# Registered Function-Select ALU

This block is a 4-bit arithmetic and logic unit whose result sits behind flip-flops. Two operands, a 4-bit function code and a mode bit select one of 32 operations: 16 bitwise logic functions when the mode bit is high, and 16 arithmetic functions when it is low. Every arithmetic function adds two operand-derived terms and an optional carry. Carries are formed by full lookahead across the word, not by rippling.

The carry input and carry output are active-low. Active-low group generate and propagate outputs let several slices be joined through an external lookahead unit. An equality flag reports an all-ones result, which in the subtract-minus-one function means the two operands are equal. All outputs change one clock after the inputs are presented.

Top module: `aluTop`

## Requirements
- R1: While `rstN` is low at a rising clock edge, the next outputs are `f`=0000, `carryOutN`=1, `genN`=1, `propN`=1 and `aEqB`=0.
- R2: Every output is registered. The values seen after rising edge k depend only on the inputs sampled at edge k.
- R3: For each bit i, two terms are formed. The first is orTerm = A | (sel[0] & B) | (sel[1] & ~B). The second is andTerm = (sel[3] & A & B) | (sel[2] & A & ~B).
- R4: When `modeLogic`=1, f = ~(orTerm ^ andTerm) bitwise. This gives A for sel=1111, B for 1010, ~B for 0101 and ~A for 0000, and `carryInN` has no effect on f.
- R5: When `modeLogic`=0, f = (orTerm + andTerm + c) mod 16, where c=1 when `carryInN`=0 and c=0 otherwise. Examples: sel=0000 with `carryInN`=0 gives A+1, and sel=1111 with `carryInN`=1 gives A-1.
- R6: In arithmetic mode, `carryOutN` is the inverse of bit 4 of the R5 sum. In logic mode, `carryOutN` is 1.
- R7: `propN` is low exactly when all four orTerm bits are 1. `genN` is low exactly when orTerm + andTerm is 16 or more, with no carry-in. Both outputs follow this rule in either mode.
- R8: `aEqB` is 1 exactly when the registered f is 1111. With sel=0110, `modeLogic`=0 and `carryInN`=1, it is therefore 1 exactly when A equals B.
- R9: With A=1010, B=1001, `modeLogic`=0 and `carryInN`=1, the results are: sel=1010 gives 0110, sel=0101 gives 1101, and sel=1111 gives 1001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| a | input | 4 | Operand A |
| b | input | 4 | Operand B |
| sel | input | 4 | Function code |
| modeLogic | input | 1 | 1 = logic functions, 0 = arithmetic functions |
| carryInN | input | 1 | Carry input, active low |
| f | output | 4 | Registered result |
| carryOutN | output | 1 | Registered carry output, active low |
| genN | output | 1 | Registered group generate, active low |
| propN | output | 1 | Registered group propagate, active low |
| aEqB | output | 1 | High when the registered result is all ones |

## Verification
The hardest condition to reach from the ports is a full-width lookahead carry. Here every orTerm bit propagates, so the carry-in alone decides the carry-out and the group generate and propagate outputs split apart. Random operands rarely produce this. The stimulus therefore sweeps all 32 function codes over many random operand pairs, and adds directed cases: all-ones operands, A=B in the subtract function, and A+1 from 1111, which wraps to zero. Every random pass also flips the carry input, so each lookahead term is exercised with and without an injected carry.

// File: rtl/aluPkg.sv
package aluPkg;
  typedef struct packed {
    logic       logicMode;
    logic       carryIn;
    logic [1:0] orSel;
    logic [1:0] andSel;
  } aluCtrl_t;
endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic [3:0] sel,
  input  logic       modeLogic,
  input  logic       carryInN,
  output aluCtrl_t   ctrl
);
  always_comb begin
    ctrl.logicMode = modeLogic;
    ctrl.carryIn   = ~carryInN & ~modeLogic;
    ctrl.orSel     = sel[1:0];
    ctrl.andSel    = sel[3:2];
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] f,
  output logic             coutN,
  output logic             gN,
  output logic             pN
);
  logic [WIDTH-1:0] orTerm, andTerm, halfSum, fNext;
  logic [WIDTH:0]   carry;
  logic             grpGen, grpProp, coutNext;

  // per-bit term formation
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign orTerm[i]  = a[i] | (ctrl.orSel[0] & b[i]) | (ctrl.orSel[1] & ~b[i]);
    assign andTerm[i] = (ctrl.andSel[1] & a[i] & b[i]) | (ctrl.andSel[0] & a[i] & ~b[i]);
    assign halfSum[i] = orTerm[i] ^ andTerm[i];
  end

  // flattened lookahead: every carry is a two-level sum of products
  always_comb begin
    logic acc;
    logic term;
    carry    = '0;
    carry[0] = ctrl.carryIn;
    grpGen   = 1'b0;
    grpProp  = 1'b1;
    for (int i = 1; i <= WIDTH; i++) begin
      acc = ctrl.carryIn;
      for (int j = 0; j < i; j++) acc = acc & orTerm[j];
      carry[i] = acc;
      for (int k = 0; k < i; k++) begin
        term = andTerm[k];
        for (int j = k + 1; j < i; j++) term = term & orTerm[j];
        carry[i] = carry[i] | term;
        if (i == WIDTH) grpGen = grpGen | term;
      end
    end
    for (int j = 0; j < WIDTH; j++) grpProp = grpProp & orTerm[j];
  end

  assign fNext    = ctrl.logicMode ? ~halfSum : (halfSum ^ carry[WIDTH-1:0]);
  assign coutNext = ctrl.logicMode ? 1'b1 : ~carry[WIDTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      f     <= '0;
      coutN <= 1'b1;
      gN    <= 1'b1;
      pN    <= 1'b1;
    end else begin
      f     <= fNext;
      coutN <= coutNext;
      gN    <= ~grpGen;
      pN    <= ~grpProp;
    end
  end
endmodule

// File: rtl/aluTop.sv
module aluTop
  import aluPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       sel,
  input  logic             modeLogic,
  input  logic             carryInN,
  output logic [WIDTH-1:0] f,
  output logic             carryOutN,
  output logic             genN,
  output logic             propN,
  output logic             aEqB
);
  aluCtrl_t ctrl;

  aluControl u_ctrl (
    .sel(sel), .modeLogic(modeLogic), .carryInN(carryInN), .ctrl(ctrl)
  );

  aluDatapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .a(a), .b(b), .ctrl(ctrl),
    .f(f), .coutN(carryOutN), .gN(genN), .pN(propN)
  );

  assign aEqB = &f;
endmodule

// File: rtl/aluChecker.sv
module aluChecker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [3:0]       sel,
  input logic             modeLogic,
  input logic             carryInN,
  input logic [WIDTH-1:0] f,
  input logic             carryOutN,
  input logic             genN,
  input logic             propN,
  input logic             aEqB
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (f == '0 && carryOutN && genN && propN && !aEqB));

  // R4
  logic_pass_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeLogic && sel == 4'b1111) |=> (f == $past(a)));

  // R4
  logic_not_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeLogic && sel == 4'b0101) |=> (f == ~$past(b)));

  // R5
  arith_incr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeLogic && sel == 4'b0000 && !carryInN) |=> (f == $past(a) + 1'b1));

  // R6
  logic_no_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeLogic |=> carryOutN);

  // R8
  equal_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeLogic && sel == 4'b0110 && carryInN) |=> (aEqB == ($past(a) == $past(b))));
endmodule

bind aluTop aluChecker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_aluTop.sv
module test_aluTop;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] a = '0, b = '0, sel = '0;
  logic       modeLogic = 1'b0, carryInN = 1'b1;
  logic [3:0] f;
  logic       carryOutN, genN, propN, aEqB;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  aluTop i_aluTop (
    .clk(clk), .rstN(rstN), .a(a), .b(b), .sel(sel), .modeLogic(modeLogic),
    .carryInN(carryInN), .f(f), .carryOutN(carryOutN), .genN(genN),
    .propN(propN), .aEqB(aEqB)
  );

  // reference: {genN, propN, carryOutN, aEqB, f}
  function automatic logic [7:0] refModel(input logic [3:0] ra, rb, rs,
                                          input logic rm, rcn);
    logic [3:0] orT, andT, rf;
    logic [4:0] sum, raw;
    logic       co;
    for (int i = 0; i < 4; i++) begin
      orT[i]  = ra[i] | (rs[0] & rb[i]) | (rs[1] & ~rb[i]);
      andT[i] = (rs[3] & ra[i] & rb[i]) | (rs[2] & ra[i] & ~rb[i]);
    end
    raw = {1'b0, orT} + {1'b0, andT};
    sum = raw + (rcn ? 5'd0 : 5'd1);
    if (rm) begin rf = ~(orT ^ andT); co = 1'b1; end
    else    begin rf = sum[3:0];      co = ~sum[4]; end
    return {~raw[4], ~(&orT), co, (rf == 4'hF), rf};
  endfunction

  task automatic cmp(input string tag, input logic [7:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b (gN,pN,coN,eq,f) a=%b b=%b s=%b m=%b cn=%b",
               tag, act, exp, a, b, sel, modeLogic, carryInN);
    end
  endtask

  task automatic apply(input logic [3:0] ta, tb, ts, input logic tm, tcn,
                       input string tag);
    @(negedge clk);
    a = ta; b = tb; sel = ts; modeLogic = tm; carryInN = tcn;
    @(posedge clk);
    #1;
    cmp(tag, {genN, propN, carryOutN, aEqB, f}, refModel(ta, tb, ts, tm, tcn));
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    a = 4'hF; b = 4'hF; sel = 4'hF; modeLogic = 1'b0; carryInN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    cmp("R1 reset", {genN, propN, carryOutN, aEqB, f}, 8'b1110_0000);
    @(negedge clk); rstN = 1'b1;

    // R9 check vectors
    apply(4'b1010, 4'b1001, 4'b1010, 1'b0, 1'b1, "R9 s1010");
    cmp("R9 value 0110", {4'b0, f}, 8'b0000_0110);
    apply(4'b1010, 4'b1001, 4'b0101, 1'b0, 1'b1, "R9 s0101");
    cmp("R9 value 1101", {4'b0, f}, 8'b0000_1101);
    apply(4'b1010, 4'b1001, 4'b1111, 1'b0, 1'b1, "R9 s1111");
    cmp("R9 value 1001", {4'b0, f}, 8'b0000_1001);
    // R4 logic selects, carry input ignored
    apply(4'b1010, 4'b1001, 4'b1111, 1'b1, 1'b0, "R4 pass A");
    cmp("R4 value A", {4'b0, f}, 8'b0000_1010);
    apply(4'b1010, 4'b1001, 4'b1010, 1'b1, 1'b1, "R4 pass B");
    apply(4'b1010, 4'b1001, 4'b0000, 1'b1, 1'b0, "R4 not A");
    cmp("R4 R6 logic carry", {7'b0, carryOutN}, 8'b1);
    // R5 / R6 wrap cases
    apply(4'hF, 4'h0, 4'b0000, 1'b0, 1'b0, "R5 R6 F plus 1");
    cmp("R6 wrap carry", {3'b0, carryOutN, f}, 8'b0000_0000);
    apply(4'h0, 4'h0, 4'b1111, 1'b0, 1'b1, "R5 0 minus 1");
    // R7 full propagate, no generate
    apply(4'h0, 4'hF, 4'b1001, 1'b0, 1'b0, "R7 propagate");
    cmp("R7 pN gN", {6'b0, genN, propN}, 8'b0000_0010);
    // R8 equality in subtract mode
    apply(4'h6, 4'h6, 4'b0110, 1'b0, 1'b1, "R8 equal");
    cmp("R8 eq high", {7'b0, aEqB}, 8'b1);
    apply(4'h6, 4'h7, 4'b0110, 1'b0, 1'b1, "R8 unequal");
    cmp("R8 eq low", {7'b0, aEqB}, 8'b0);

    // R2 R3 R4 R5 R6 R7: all 32 functions over random operands
    for (int rep = 0; rep < 24; rep++) begin
      for (int fn = 0; fn < 32; fn++) begin
        apply(4'($urandom), 4'($urandom), fn[3:0], fn[4], rep[0], "R3 sweep");
      end
    end

    // R1 reset in mid-run clears outputs
    @(negedge clk);
    a = 4'hF; b = 4'h0; sel = 4'hF; modeLogic = 1'b1; rstN = 1'b0;
    @(posedge clk); #1;
    cmp("R1 mid reset", {genN, propN, carryOutN, aEqB, f}, 8'b1110_0000);
    @(negedge clk); rstN = 1'b1;
    apply(4'h3, 4'h5, 4'b1001, 1'b0, 1'b1, "R2 after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule